// File: doc/BRIEF.md
# Write-Combining Store Buffer with Bounded Drain

This block sits between a processor's store port and a memory write port. It holds a single cache line. Stores to cacheable, mergeable memory that hit the held line are folded into a line-wide data register, and a per-byte mask records which bytes have been written since the line was allocated. Each store carries address, data, byte strobes and a memory-type flag. Stores flagged as non-mergeable skip the merge register. They go out as single-store line writes, in program order with the held line.

The held line is written out in three cases: a store to another line arrives, a barrier request arrives, or a drain timer runs out. By default the timer starts when the line is allocated, and later merges do not restart it. A loop that keeps writing the same line therefore still makes its data visible within a fixed bound. A parameter selects a legacy variant in which every merge restarts the timer. This reproduces the starvation hazard, where a polling agent never sees an update that keeps being rewritten.

A barrier is acknowledged only once the memory side has taken the held line. If nothing is held or pending, the barrier is acknowledged at once.

Top module: `wc_store_buf`

## Requirements
- R1: After reset the buffer holds nothing, `wr_valid_o` is 0, `st_ready_o` is 1 and `bar_ack_o` is 0 while `bar_req_i` is 0.
- R2: A mergeable store (`st_normal_i`=1) to the held line is accepted in the same cycle and causes no output write. Later writes to an already written byte replace its value and do not create a new write.
- R3: A non-mergeable store (`st_normal_i`=0) accepted while the buffer is empty is presented on the output in the next cycle. It appears as one line write at the line-aligned address, with only its strobed bytes set in the mask, in word lane `st_addr_i[4:2]`.
- R4: While a line is held, a store to a different line or a non-mergeable store is stalled (`st_ready_o`=0). The held line is presented on the output in the next cycle. The stalled store is accepted once that write has been taken.
- R5: With `RESTART_ON_MERGE`=0, the held line is presented on the output exactly `DRAIN_CYCLES`+1 cycles after the store that allocated it was accepted, whatever merges happen in between.
- R6: With `RESTART_ON_MERGE`=1, each merge restarts the timer. The line is presented `DRAIN_CYCLES`+1 cycles after the last merge.
- R7: A barrier request forces a held line out. `bar_ack_o` is 1 only in the cycle in which that write is accepted (`wr_valid_o` and `wr_ready_i` both 1). With no line held and no write pending, `bar_ack_o` is 1 in the same cycle as `bar_req_i`.
- R8: On a line write, `wr_addr_o` has its low 5 bits at zero. Bit i of `wr_mask_o` is set exactly for byte i written since allocation. Byte i of `wr_data_o` (bits 8i+7..8i) holds the last value written to it, and unmasked bytes are zero. Store byte b (`st_data_i[8b+7:8b]`, strobe bit b) maps to line byte 4*`st_addr_i[4:2]`+b.
- R9: While `wr_valid_o`=1 and `wr_ready_i`=0, the address, mask and data stay unchanged and no store is accepted.
- R10: A store to the held line that arrives in the cycle the timer expires is not accepted. Once the drain completes it is accepted as a new allocation, and the next write carries only its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store accepted this cycle when valid |
| st_addr_i | input | 32 | Store byte address |
| st_data_i | input | 32 | Store data, byte b in bits 8b+7..8b |
| st_strb_i | input | 4 | Byte strobes |
| st_normal_i | input | 1 | 1 = mergeable memory, 0 = issue directly |
| bar_req_i | input | 1 | Barrier request, held until acknowledged |
| bar_ack_o | output | 1 | Barrier acknowledge |
| wr_valid_o | output | 1 | Line write valid |
| wr_ready_i | input | 1 | Memory side accepts the line write |
| wr_addr_o | output | 32 | Line-aligned write address |
| wr_data_o | output | 256 | Line data |
| wr_mask_o | output | 32 | Per-byte write mask |

## Verification
If the drain timer were wrong, for example restarting on merges or counting from the wrong cycle, the line write would appear on a cycle other than the allocation cycle plus `DRAIN_CYCLES`+1. The bench checks that exact cycle both in directed runs and on every allocation during random traffic. If the byte mask or the data register were wrong, the next accepted line write would show missing, extra or stale bytes against a model built from the accepted stores. If the held tag were wrong, the same write would show a wrong address, or a store to another line would be accepted while the old one is still held. Both of those show up no later than the next drain.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2
  } wcb_state_e;
endpackage

// File: rtl/wcb_line_reg.sv
module wcb_line_reg #(
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  localparam int WORDS     = LINE_BYTES / WORD_BYTES,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      fresh_i,
  input  logic [IDX_W-1:0]          word_i,
  input  logic [WORD_BYTES*8-1:0]   data_i,
  input  logic [WORD_BYTES-1:0]     strb_i,
  output logic [LINE_BYTES*8-1:0]   data_o,
  output logic [LINE_BYTES-1:0]     mask_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic lane_sel;
    assign lane_sel = (word_i == IDX_W'(w));
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
      localparam int I = w * WORD_BYTES + b;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_o[I*8 +: 8] <= '0;
          mask_o[I]        <= 1'b0;
        end else if (wr_en_i) begin
          if (lane_sel && strb_i[b]) begin
            data_o[I*8 +: 8] <= data_i[b*8 +: 8];
            mask_o[I]        <= 1'b1;
          end else if (fresh_i) begin
            // allocation wipes bytes from the previous line
            data_o[I*8 +: 8] <= '0;
            mask_o[I]        <= 1'b0;
          end
        end
      end
    end
  end

  assert_fresh_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && fresh_i) |=> ($countones(mask_o) <= WORD_BYTES));
endmodule

// File: rtl/wcb_drain_timer.sv
module wcb_drain_timer #(
  parameter int DRAIN_CYCLES     = 16,
  parameter bit RESTART_ON_MERGE = 1'b0,
  localparam int CNT_W           = $clog2(DRAIN_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic merge_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DRAIN_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clr;

  assign clr      = start_i | (RESTART_ON_MERGE & merge_i);
  assign expire_o = run_i && (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= LIM));
endmodule

// File: rtl/wc_store_buf.sv
module wc_store_buf #(
  parameter int ADDR_W           = 32,
  parameter int LINE_BYTES       = 32,
  parameter int WORD_BYTES       = 4,
  parameter int DRAIN_CYCLES     = 16,
  parameter bit RESTART_ON_MERGE = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [WORD_BYTES*8-1:0] st_data_i,
  input  logic [WORD_BYTES-1:0]   st_strb_i,
  input  logic                    st_normal_i,
  input  logic                    bar_req_i,
  output logic                    bar_ack_o,
  output logic                    wr_valid_o,
  input  logic                    wr_ready_i,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [LINE_BYTES*8-1:0] wr_data_o,
  output logic [LINE_BYTES-1:0]   wr_mask_o
);
  import wcb_pkg::*;

  localparam int LINE_OFF = $clog2(LINE_BYTES);
  localparam int WORD_OFF = $clog2(WORD_BYTES);
  localparam int IDX_W    = LINE_OFF - WORD_OFF;
  localparam int TAG_W    = ADDR_W - LINE_OFF;
  localparam int AGE_W    = $clog2(DRAIN_CYCLES + 2);

  wcb_state_e       state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] st_tag;
  logic [IDX_W-1:0] st_word;
  logic             mergeable, expire, alloc, merge;
  logic             unused_low;

  assign st_tag     = st_addr_i[ADDR_W-1:LINE_OFF];
  assign st_word    = st_addr_i[LINE_OFF-1:WORD_OFF];
  assign unused_low = ^st_addr_i[WORD_OFF-1:0];
  assign mergeable  = st_normal_i && (st_tag == tag_q);

  always_comb begin
    state_d    = state_q;
    st_ready_o = 1'b0;
    bar_ack_o  = 1'b0;
    alloc      = 1'b0;
    merge      = 1'b0;
    unique case (state_q)
      ST_EMPTY: begin
        st_ready_o = 1'b1;
        bar_ack_o  = bar_req_i;  // store taken this cycle orders after it
        if (st_valid_i) begin
          alloc   = 1'b1;
          state_d = st_normal_i ? ST_HOLD : ST_DRAIN;
        end
      end
      ST_HOLD: begin
        if (expire || bar_req_i || (st_valid_i && !mergeable)) begin
          state_d = ST_DRAIN;
        end else begin
          st_ready_o = 1'b1;
          merge      = st_valid_i;
        end
      end
      ST_DRAIN: begin
        if (wr_ready_i) begin
          state_d   = ST_EMPTY;
          bar_ack_o = bar_req_i;
        end
      end
      default: state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_EMPTY;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      if (alloc) tag_q <= st_tag;
    end
  end

  wcb_line_reg #(
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES)
  ) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(alloc | merge),
    .fresh_i(alloc),
    .word_i (st_word),
    .data_i (st_data_i),
    .strb_i (st_strb_i),
    .data_o (wr_data_o),
    .mask_o (wr_mask_o)
  );

  wcb_drain_timer #(
    .DRAIN_CYCLES    (DRAIN_CYCLES),
    .RESTART_ON_MERGE(RESTART_ON_MERGE)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (alloc),
    .merge_i (merge),
    .run_i   (state_q == ST_HOLD),
    .expire_o(expire)
  );

  assign wr_valid_o = (state_q == ST_DRAIN);
  assign wr_addr_o  = {tag_q, {LINE_OFF{1'b0}}};

  // independent residency counter for the visibility bound
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 age_q <= '0;
    else if (state_q != ST_HOLD) age_q <= '0;
    else if (age_q != '1)        age_q <= age_q + 1'b1;
  end

  assert_visibility_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!RESTART_ON_MERGE && state_q == ST_HOLD) |-> (age_q < AGE_W'(DRAIN_CYCLES)));
  assert_out_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_mask_o) && $stable(wr_data_o)));
  assert_no_take_while_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !st_ready_o);
  assert_ack_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bar_ack_o |-> (bar_req_i && state_q != ST_HOLD && (!wr_valid_o || wr_ready_i)));
  assert_nonempty_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_mask_o != '0));
  assert_tag_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_EMPTY && $past(state_q) != ST_EMPTY) |-> $stable(wr_addr_o));
endmodule

// File: tb/wc_store_buf_bench.sv
module wc_store_buf_bench;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         st_valid_i = 0, st_normal_i = 1, bar_req_i = 0, wr_ready_i = 1;
  logic [31:0]  st_addr_i = '0, st_data_i = '0;
  logic [3:0]   st_strb_i = '0;
  logic         st_ready_o, bar_ack_o, wr_valid_o;
  logic [31:0]  wr_addr_o;
  logic [255:0] wr_data_o;
  logic [31:0]  wr_mask_o;

  wc_store_buf #(.DRAIN_CYCLES(D), .RESTART_ON_MERGE(1'b0)) u_wc_store_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .st_addr_i(st_addr_i),
    .st_data_i(st_data_i), .st_strb_i(st_strb_i), .st_normal_i(st_normal_i),
    .bar_req_i(bar_req_i), .bar_ack_o(bar_ack_o),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o));

  logic         lg_valid = 0;
  logic [31:0]  lg_addr = '0;
  logic         lg_ready, lg_ack, lg_wvalid;
  logic [31:0]  lg_waddr, lg_wmask;
  logic [255:0] lg_wdata;

  wc_store_buf #(.DRAIN_CYCLES(D), .RESTART_ON_MERGE(1'b1)) u_wc_store_buf_legacy (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(lg_valid), .st_ready_o(lg_ready), .st_addr_i(lg_addr),
    .st_data_i(32'h0102_0304), .st_strb_i(4'hF), .st_normal_i(1'b1),
    .bar_req_i(1'b0), .bar_ack_o(lg_ack),
    .wr_valid_o(lg_wvalid), .wr_ready_i(1'b1), .wr_addr_o(lg_waddr),
    .wr_data_o(lg_wdata), .wr_mask_o(lg_wmask));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // transaction model
  bit           m_held = 0, m_byp = 0;
  logic [26:0]  m_tag, b_tag;
  logic [255:0] m_data, b_data;
  logic [31:0]  m_mask, b_mask, last_wmask;
  int           m_alloc = 0;
  bit           acc, wacc, ackd;

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void put_bytes(inout logic [255:0] d, inout logic [31:0] m,
                                    input logic [31:0] a, input logic [31:0] v, input logic [3:0] s);
    for (int b = 0; b < 4; b++)
      if (s[b]) begin
        d[(a[4:2]*4 + b)*8 +: 8] = v[b*8 +: 8];
        m[a[4:2]*4 + b] = 1'b1;
      end
  endfunction

  task automatic model_write();
    last_wmask = wr_mask_o;
    if (m_held) begin
      check(wr_addr_o == {m_tag, 5'b0}, "R8 addr", wr_addr_o, {m_tag, 5'b0});
      check(wr_mask_o == m_mask, "R8 mask", wr_mask_o, m_mask);
      check(wr_data_o == m_data, "R8 data", wr_data_o, m_data);
      m_held = 0;
    end else if (m_byp) begin
      check(wr_addr_o == {b_tag, 5'b0}, "R3 addr", wr_addr_o, {b_tag, 5'b0});
      check(wr_mask_o == b_mask, "R3 mask", wr_mask_o, b_mask);
      check(wr_data_o == b_data, "R3 data", wr_data_o, b_data);
      m_byp = 0;
    end else check(0, "R2 unexpected write", wr_addr_o, 0);
  endtask

  task automatic model_store();
    if (!st_normal_i) begin
      check(!m_held && !m_byp, "R4 bypass ordering", m_held, 0);
      m_byp = 1; b_tag = st_addr_i[31:5]; b_data = '0; b_mask = '0;
      put_bytes(b_data, b_mask, st_addr_i, st_data_i, st_strb_i);
    end else if (m_held) begin
      check(st_addr_i[31:5] == m_tag, "R4 foreign line taken", st_addr_i[31:5], m_tag);
      put_bytes(m_data, m_mask, st_addr_i, st_data_i, st_strb_i);
    end else begin
      m_held = 1; m_tag = st_addr_i[31:5]; m_data = '0; m_mask = '0; m_alloc = cyc;
      put_bytes(m_data, m_mask, st_addr_i, st_data_i, st_strb_i);
    end
  endtask

  // inputs are set after a falling edge; handshakes resolve before the next rise
  task automatic tick();
    #1;
    acc = st_valid_i && st_ready_o;
    wacc = wr_valid_o && wr_ready_i;
    ackd = bar_ack_o;
    if (m_held && (cyc - m_alloc == D + 1))
      check(wr_valid_o, "R5 drain bound", wr_valid_o, 1);
    if (wacc) model_write();
    if (ackd) check(!m_held && !m_byp, "R7 early ack", m_held, 0);
    if (acc) model_store();
    @(negedge clk);
    cyc++;
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] v, input logic [3:0] s, input logic n);
    st_valid_i = 1; st_addr_i = a; st_data_i = v; st_strb_i = s; st_normal_i = n;
  endtask

  task automatic drain_all();
    st_valid_i = 0; wr_ready_i = 1;
    for (int i = 0; i < 3 * D && (m_held || m_byp); i++) tick();
    check(!m_held && !m_byp, "R5 line left behind", m_held, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] sd;
    logic [31:0] sm;
    int k_vis;
    @(negedge clk);
    #1;
    check(!wr_valid_o && !bar_ack_o, "R1 reset outputs", {wr_valid_o, bar_ack_o}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(st_ready_o && !wr_valid_o && !bar_ack_o, "R1 idle after reset",
          {st_ready_o, wr_valid_o, bar_ack_o}, 3'b100);
    @(negedge clk);

    // R6: legacy instance restarts on merge
    lg_valid = 1; lg_addr = 32'h100; k_vis = -1;
    for (int k = 0; k <= 40; k++) begin
      lg_valid = (k == 0 || k == 5 || k == 10);
      lg_addr = (k == 0) ? 32'h100 : 32'h104;
      #1;
      if (lg_valid) check(lg_ready, "R6 merge taken", lg_ready, 1);
      if (lg_wvalid && k_vis < 0) k_vis = k;
      @(negedge clk);
    end
    lg_valid = 0;
    check(k_vis == 10 + D + 1, "R6 restart timing", k_vis, 10 + D + 1);
    check(lg_wmask == 32'h0000_00FF, "R6 merged mask", lg_wmask, 32'hFF);

    // R2/R5/R10: a steady stream to one line still drains on time
    drive(32'h100, 32'hAABB_CCDD, 4'hF, 1);
    tick();
    check(acc, "R2 first store", acc, 1);
    for (int k = 1; k <= D + 2; k++) begin
      if (k < D) begin
        if (k[0]) drive(32'h104, k, 4'hF, 1);
        else      drive(32'h100, 32'h1111_0000 + k, 4'h3, 1);
      end else drive(32'h108, 32'h5566_7788, 4'hF, 1);
      tick();
      if (k < D) begin
        check(acc, "R2 merge accepted", acc, 1);
        check(!wacc, "R2 merge issued no write", wacc, 0);
      end
      if (k == D) check(!acc, "R10 held in expiry cycle", acc, 0);
      if (k == D + 1) check(wacc, "R5 written on time", wacc, 1);
      if (k == D + 2) begin
        check(acc, "R10 new allocation", acc, 1);
        break;
      end
    end
    drain_all();
    check(last_wmask == 32'h0000_0F00, "R10 fresh mask", last_wmask, 32'hF00);

    // R3/R9: bypass with back-pressure
    wr_ready_i = 0;
    drive(32'h204, 32'h1122_3344, 4'hC, 0);
    tick();
    check(acc, "R3 bypass taken", acc, 1);
    drive(32'h300, 32'h9, 4'h1, 1);
    tick();
    check(wr_valid_o && wr_addr_o == 32'h200, "R3 next cycle", wr_addr_o, 32'h200);
    check(wr_mask_o == 32'h0000_00C0, "R3 lane mask", wr_mask_o, 32'hC0);
    check(wr_data_o[63:48] == 16'h1122, "R3 lane data", wr_data_o[63:48], 16'h1122);
    check(!acc, "R9 store stalled", acc, 0);
    sd = wr_data_o; sm = wr_mask_o;
    tick(); tick();
    check(wr_valid_o && wr_data_o == sd && wr_mask_o == sm, "R9 output stable", wr_mask_o, sm);
    check(!acc, "R9 still stalled", acc, 0);
    wr_ready_i = 1;
    tick();
    check(wacc, "R9 write taken", wacc, 1);
    tick();
    check(acc, "R9 store after drain", acc, 1);
    drain_all();

    // R4: foreign line and non-mergeable store force a drain first
    drive(32'h400, 32'hA, 4'hF, 1);
    tick();
    drive(32'h420, 32'hB, 4'hF, 1);
    tick();
    check(!acc && !wacc, "R4 foreign stalled", acc, 0);
    tick();
    check(wacc && wr_addr_o == 32'h400, "R4 old line out", wr_addr_o, 32'h400);
    tick();
    check(acc, "R4 foreign accepted", acc, 1);
    drive(32'h424, 32'hC, 4'hF, 0);
    tick();
    check(!acc, "R4 non-mergeable stalled", acc, 0);
    tick();
    check(wacc && wr_addr_o == 32'h420, "R4 held line first", wr_addr_o, 32'h420);
    tick();
    check(acc, "R4 non-mergeable accepted", acc, 1);
    drain_all();

    // R7: barrier waits for acceptance
    drive(32'h500, 32'h77, 4'h1, 1);
    tick();
    st_valid_i = 0; bar_req_i = 1; wr_ready_i = 0;
    tick();
    check(!ackd, "R7 no ack while held", ackd, 0);
    tick();
    check(wr_valid_o && !ackd, "R7 no ack under stall", ackd, 0);
    wr_ready_i = 1;
    tick();
    check(ackd && wacc, "R7 ack with acceptance", {ackd, wacc}, 2'b11);
    bar_req_i = 0;
    tick();
    bar_req_i = 1;
    tick();
    check(ackd, "R7 empty ack", ackd, 1);
    bar_req_i = 0;
    tick();

    // random traffic on two lines
    void'($urandom(32'h5EED_0042));
    st_valid_i = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!st_valid_i || acc) begin
        if ($urandom_range(0, 3) != 0) begin
          drive({23'h0, 1'b1, $urandom_range(0, 1) == 1, 2'b00, 3'($urandom_range(0, 7)), 2'b00},
                $urandom, 4'($urandom_range(1, 15)), $urandom_range(0, 9) != 0);
        end else st_valid_i = 0;
      end
      if (bar_req_i && ackd) bar_req_i = 0;
      else if (!bar_req_i && $urandom_range(0, 39) == 0) bar_req_i = 1;
      wr_ready_i = $urandom_range(0, 9) < 7;
      tick();
    end
    bar_req_i = 0;
    if (acc) st_valid_i = 0;
    st_valid_i = 0;
    drain_all();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule